// File: doc/BRIEF.md
# Two-Way Lockable Data Cache

This block is a blocking data cache that sits between a processor load/store port and a simple word-wide memory port. It has two ways and is indexed and tagged by physical address. Each line holds four words. A lookup that hits answers in the same cycle the request is presented. A lookup that misses spends one extra clock choosing a victim. If the victim is dirty, the cache then writes it out as a burst, and then it fetches the new line as a burst that starts at the requested word.

Every request carries two page attributes from address translation. The first selects write-through or copy-back for that access. The second marks the access cache-inhibited, which sends it straight to memory as a single beat without allocating a line. A request can also lock the line it touches, or unlock it. A locked line is never replaced. When both ways of a set are locked, a miss in that set is served like an uncached access.

The requester holds a request stable until `rsp_valid` is seen high, then it may present the next request in the following cycle. The memory port keeps `mem_req` high for each beat, and the memory acknowledges each beat with `mem_ack`.

Top module: `lockable_dcache`

## Requirements
- R1: After reset every line is invalid and unlocked, `rsp_valid` and `mem_req` are low, and the first access to any address misses.
- R2: A read or copy-back write that hits raises `rsp_valid` combinationally in the cycle the request is presented, with the read word on `rsp_rdata`.
- R3: A cacheable miss whose victim is clean waits one idle clock, then runs a four-beat read burst (`mem_burst`=1, `mem_we`=0). It responds 6 clocks after presentation with the correct word.
- R4: Line fill beats carry word offsets (address bits [3:2] with 32-bit words) starting at the requested word and incrementing modulo 4.
- R5: The victim is an invalid unlocked way if there is one; otherwise it is the less recently used way, where a hit or a completed fill counts as a use.
- R6: A copy-back store hit updates the line, marks it dirty and makes no memory write. Evicting a dirty line first writes its four words as a write burst, then fills, and the response comes 10 clocks after presentation.
- R7: A write-through store makes exactly one single-beat memory write and responds 1 clock after presentation. It updates the line on a hit and allocates nothing on a miss.
- R8: A cache-inhibited read or write is one single-beat memory access at the request address, responds 1 clock after presentation, and allocates no line.
- R9: `req_lock` on an access sets the lock bit of the line on its hit, including the hit that follows a fill. `req_unlock` on a hit clears it. A locked line is never chosen as victim.
- R10: A cacheable miss in a set whose two ways are both locked is served as a single-beat uncached access and allocates nothing.
- R11: Every read returns the value most recently stored to that address, under any mix of write policies, evictions and fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `rsp_valid` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Physical byte address |
| req_wdata | input | DW | Store data |
| req_wt | input | 1 | Page attribute: write-through (1) or copy-back (0) |
| req_ci | input | 1 | Page attribute: cache-inhibited |
| req_lock | input | 1 | Lock the accessed line |
| req_unlock | input | 1 | Unlock the accessed line on a hit |
| rsp_valid | output | 1 | Access complete |
| rsp_rdata | output | DW | Load data |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory write |
| mem_burst | output | 1 | Beat belongs to a four-beat line transfer |
| mem_addr | output | AW | Word-aligned beat address |
| mem_wdata | output | DW | Write data for the beat |
| mem_ack | input | 1 | Beat accepted / read data valid |
| mem_rdata | input | DW | Read data for the beat |

## Verification
The bench drives three kinds of access patterns.

The first kind is directed sequences whose latency alone tells the paths apart:
- 0 clocks for a hit,
- 1 clock for an uncached or write-through access,
- 6 clocks for a clean fill,
- 10 clocks for a dirty eviction.

The second kind is access orders within one set built to separate LRU replacement from lock protection and from the fallback used when both ways are locked. The model memory's contents, inspected right after each store, show whether the cache is write-through, deferred copy-back, or write-back on eviction.

The third kind is a sweep over every set and word with several tags and alternating write policy. It checks each read against an arithmetically computed coherent image.

// File: rtl/dc_pkg.sv
package dc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MISS,
      ST_WB,
      ST_FILL,
      ST_SINGLE
   } dc_state_e;
endpackage

// File: rtl/dc_way.sv
// One way: tag, valid, dirty and lock flags, and line data per set.
module dc_way #(
   parameter int SETS  = 16,
   parameter int WORDS = 4,
   parameter int TAGW  = 20,
   parameter int DW    = 32,
   localparam int IDXW = $clog2(SETS),
   localparam int OFFW = $clog2(WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IDXW-1:0] idx,
   input  logic [OFFW-1:0] word_sel,
   output logic [TAGW-1:0] tag_o,
   output logic            valid_o,
   output logic            dirty_o,
   output logic            lock_o,
   output logic [DW-1:0]   rdata_o,
   input  logic            data_we,
   input  logic [OFFW-1:0] data_word,
   input  logic [DW-1:0]   data_wd,
   input  logic            install,
   input  logic [TAGW-1:0] tag_i,
   input  logic            dirty_set,
   input  logic            lock_we,
   input  logic            lock_val
);
   logic [TAGW-1:0] tag_q  [SETS];
   logic [DW-1:0]   data_q [SETS][WORDS];
   logic [SETS-1:0] valid_q, dirty_q, lock_q;

   assign tag_o   = tag_q[idx];
   assign valid_o = valid_q[idx];
   assign dirty_o = dirty_q[idx];
   assign lock_o  = lock_q[idx];
   assign rdata_o = data_q[idx][word_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
         lock_q  <= '0;
      end else begin
         if (install) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
            lock_q[idx]  <= 1'b0;
         end
         if (dirty_set) dirty_q[idx] <= 1'b1;
         if (lock_we)   lock_q[idx]  <= lock_val;
      end
   end

   always_ff @(posedge clk) begin
      if (install) tag_q[idx] <= tag_i;
      if (data_we) data_q[idx][data_word] <= data_wd;
   end
endmodule

// File: rtl/dc_lru.sv
// Per-set replacement state for two ways, with lock-aware victim choice.
module dc_lru #(
   parameter int SETS  = 16,
   localparam int IDXW = $clog2(SETS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IDXW-1:0] idx,
   input  logic            touch,
   input  logic            touch_way,
   input  logic [1:0]      valid,
   input  logic [1:0]      lock,
   output logic            victim,
   output logic            victim_ok
);
   logic [SETS-1:0] old_q;   // way to evict next

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     old_q <= '0;
      else if (touch) old_q[idx] <= ~touch_way;
   end

   always_comb begin
      if (!valid[0] && !lock[0])      victim = 1'b0;
      else if (!valid[1] && !lock[1]) victim = 1'b1;
      else if (lock[old_q[idx]])      victim = ~old_q[idx];
      else                            victim = old_q[idx];
   end

   assign victim_ok = ~(lock[0] & lock[1]);
endmodule

// File: rtl/lockable_dcache.sv
module lockable_dcache
   import dc_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int SETS  = 16,
   parameter int WORDS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          req_wt,
   input  logic          req_ci,
   input  logic          req_lock,
   input  logic          req_unlock,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_burst,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata
);
   localparam int BYTEW = $clog2(DW / 8);
   localparam int OFFW  = $clog2(WORDS);
   localparam int IDXW  = $clog2(SETS);
   localparam int TAGW  = AW - IDXW - OFFW - BYTEW;
   localparam logic [OFFW-1:0] LAST_BEAT = OFFW'(WORDS - 1);

   if (DW < 16 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("DW must be a power of two of at least 16");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (TAGW < 1) begin : g_bad_aw
      $error("AW too small for the chosen geometry");
   end

   wire [IDXW-1:0] req_idx  = req_addr[BYTEW+OFFW +: IDXW];
   wire [OFFW-1:0] req_word = req_addr[BYTEW +: OFFW];
   wire [TAGW-1:0] req_tag  = req_addr[AW-1 -: TAGW];
   wire [BYTEW-1:0] zb = '0;

   dc_state_e       state_q, nxt;
   logic [OFFW-1:0] beat_q, beat_d, word_sel, data_word;
   logic            vict_q, vict_d, vict_way, vict_ok, touch, lock_val;
   logic [DW-1:0]   data_wd;
   logic [1:0]      data_we, install, dirty_set, lock_we;

   logic [TAGW-1:0] way_tag   [2];
   logic [DW-1:0]   way_rdata [2];
   logic [1:0]      way_valid, way_dirty, way_lock, hit_vec;

   for (genvar w = 0; w < 2; w++) begin : g_way
      dc_way #(.SETS(SETS), .WORDS(WORDS), .TAGW(TAGW), .DW(DW)) u_way (
         .clk(clk), .rst_n(rst_n), .idx(req_idx), .word_sel(word_sel),
         .tag_o(way_tag[w]), .valid_o(way_valid[w]), .dirty_o(way_dirty[w]),
         .lock_o(way_lock[w]), .rdata_o(way_rdata[w]),
         .data_we(data_we[w]), .data_word(data_word), .data_wd(data_wd),
         .install(install[w]), .tag_i(req_tag), .dirty_set(dirty_set[w]),
         .lock_we(lock_we[w]), .lock_val(lock_val)
      );
      assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
   end

   wire hit     = |hit_vec;
   wire hit_way = hit_vec[1];
   wire [OFFW-1:0] fill_word = req_word + beat_q;

   dc_lru #(.SETS(SETS)) u_lru (
      .clk(clk), .rst_n(rst_n), .idx(req_idx), .touch(touch), .touch_way(hit_way),
      .valid(way_valid), .lock(way_lock), .victim(vict_way), .victim_ok(vict_ok)
   );

   always_comb begin
      nxt       = state_q;
      beat_d    = beat_q;
      vict_d    = vict_q;
      data_we   = '0;
      install   = '0;
      dirty_set = '0;
      lock_we   = '0;
      lock_val  = req_lock;
      data_word = req_word;
      data_wd   = req_wdata;
      word_sel  = req_word;
      touch     = 1'b0;
      rsp_valid = 1'b0;
      rsp_rdata = way_rdata[hit_way];
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_burst = 1'b0;
      mem_addr  = {req_addr[AW-1:BYTEW], zb};
      mem_wdata = req_wdata;
      unique case (state_q)
         ST_IDLE: if (req_valid) begin
            if (req_ci) nxt = ST_SINGLE;
            else if (hit) begin
               touch = 1'b1;
               if (req_write) begin
                  data_we[hit_way] = 1'b1;
                  if (req_wt) nxt = ST_SINGLE;
                  else dirty_set[hit_way] = 1'b1;
               end
               if (req_lock || req_unlock) lock_we[hit_way] = 1'b1;
               rsp_valid = !(req_write && req_wt);
            end else if ((req_write && req_wt) || !vict_ok) nxt = ST_SINGLE;
            else begin
               nxt    = ST_MISS;
               vict_d = vict_way;
            end
         end
         ST_MISS: begin
            beat_d = '0;
            nxt    = (way_valid[vict_q] && way_dirty[vict_q]) ? ST_WB : ST_FILL;
         end
         ST_WB: begin
            word_sel  = beat_q;
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_burst = 1'b1;
            mem_addr  = {way_tag[vict_q], req_idx, beat_q, zb};
            mem_wdata = way_rdata[vict_q];
            if (mem_ack) begin
               beat_d = beat_q + 1'b1;
               if (beat_q == LAST_BEAT) nxt = ST_FILL;
            end
         end
         ST_FILL: begin
            mem_req   = 1'b1;
            mem_burst = 1'b1;
            mem_addr  = {req_tag, req_idx, fill_word, zb};
            if (mem_ack) begin
               data_we[vict_q] = 1'b1;
               data_word       = fill_word;
               data_wd         = mem_rdata;
               beat_d          = beat_q + 1'b1;
               if (beat_q == LAST_BEAT) begin
                  install[vict_q] = 1'b1;
                  nxt             = ST_IDLE;
               end
            end
         end
         ST_SINGLE: begin
            mem_req = 1'b1;
            mem_we  = req_write;
            if (mem_ack) begin
               rsp_valid = 1'b1;
               rsp_rdata = mem_rdata;
               nxt       = ST_IDLE;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         vict_q  <= 1'b0;
      end else begin
         state_q <= nxt;
         beat_q  <= beat_d;
         vict_q  <= vict_d;
      end
   end
endmodule

// File: rtl/lockable_dcache_chk.sv
module lockable_dcache_chk #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int WORDS = 4,
   localparam int BYTEW = $clog2(DW / 8),
   localparam int OFFW  = $clog2(WORDS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [AW-1:0] req_addr,
   input logic          rsp_valid,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_burst,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr,
   input logic          in_miss,
   input logic          vict_lock,
   input logic [1:0]    hit_vec
);
   logic [OFFW:0] wcnt, rcnt;
   wire fill_ack = mem_req && mem_burst && !mem_we && mem_ack;
   wire wb_ack   = mem_req && mem_burst && mem_we && mem_ack;
   wire [OFFW-1:0] beat_word = mem_addr[BYTEW +: OFFW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt <= '0;
         rcnt <= '0;
      end else if (!mem_req) begin
         wcnt <= '0;
         rcnt <= '0;
      end else begin
         if (wb_ack && wcnt < (OFFW+1)'(WORDS))   wcnt <= wcnt + 1'b1;
         if (fill_ack && rcnt < (OFFW+1)'(WORDS)) rcnt <= rcnt + 1'b1;
      end
   end

   AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_valid); // R2
   AST_FILL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      fill_ack |-> rcnt < (OFFW+1)'(WORDS)); // R3
   AST_FILL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_ack && $past(fill_ack)) |-> beat_word == $past(beat_word) + 1'b1); // R4
   AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R5
   AST_WB_DONE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_burst && !mem_we) |-> (wcnt == '0 || wcnt == (OFFW+1)'(WORDS))); // R6
   AST_SINGLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_burst) |-> mem_addr[AW-1:BYTEW] == req_addr[AW-1:BYTEW]); // R8
   AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      in_miss |-> !vict_lock); // R9
endmodule

bind lockable_dcache lockable_dcache_chk #(.AW(AW), .DW(DW), .WORDS(WORDS)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .rsp_valid(rsp_valid), .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst),
   .mem_ack(mem_ack), .mem_addr(mem_addr), .in_miss(state_q == dc_pkg::ST_MISS),
   .vict_lock(way_lock[vict_q]), .hit_vec(hit_vec)
);

// File: tb/lockable_dcache_tb_top.sv
module lockable_dcache_tb_top;
   localparam int AW = 12, DW = 32, SETS = 4, WORDS = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, req_valid, req_write, req_wt, req_ci, req_lock, req_unlock;
   logic [AW-1:0] req_addr, mem_addr;
   logic [DW-1:0] req_wdata, rsp_rdata, mem_wdata, mem_rdata;
   logic rsp_valid, mem_req, mem_we, mem_burst, mem_ack;

   lockable_dcache #(.AW(AW), .DW(DW), .SETS(SETS), .WORDS(WORDS)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_wt(req_wt), .req_ci(req_ci),
      .req_lock(req_lock), .req_unlock(req_unlock), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   logic [31:0] bmem [1024];
   logic [31:0] gold [1024];
   int total = 0, bad = 0;
   int wr_beats = 0, rd_beats = 0, single_beats = 0, fill_n = 0;
   int fill_log [4];

   // memory model: acknowledges one beat per cycle, commits at the falling edge
   initial begin
      mem_ack = 1'b0;
      mem_rdata = '0;
      for (int i = 0; i < 1024; i++) begin
         bmem[i] = 32'hC0DE_0000 + 32'(i);
         gold[i] = 32'hC0DE_0000 + 32'(i);
      end
      forever begin
         @(negedge clk);
         mem_ack = mem_req;
         if (mem_req) begin
            int widx;
            widx = int'(mem_addr[AW-1:2]);
            if (mem_we) bmem[widx] = mem_wdata;
            else mem_rdata = bmem[widx];
            if (!mem_burst) single_beats++;
            else if (mem_we) wr_beats++;
            else begin
               fill_log[fill_n % 4] = int'(mem_addr[3:2]);
               fill_n++;
            end
            if (mem_burst && !mem_we) rd_beats++;
         end
      end
   end

   function automatic int adr(int t, int s, int w);
      return t * 64 + s * 16 + w * 4;
   endfunction

   task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   task automatic acc(input bit wr, input int a, input logic [31:0] wd, input bit wt, input bit ci,
                      input bit lk, input bit ul, output logic [31:0] rd, output int lat);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = wd;
      req_wt = wt; req_ci = ci; req_lock = lk; req_unlock = ul;
      lat = 0;
      forever begin
         #1;
         if (rsp_valid) break;
         @(negedge clk);
         lat++;
         if (lat > 50) break;
      end
      rd = rsp_rdata;
      @(posedge clk);
      #1;
      req_valid = 1'b0; req_write = 1'b0; req_lock = 1'b0; req_unlock = 1'b0;
      req_wt = 1'b0; req_ci = 1'b0;
      if (wr) gold[a >> 2] = wd;
   endtask

   task automatic rd_chk(input int a, input int exp_lat, input bit ci, input bit lk, input bit ul,
                         input string r);
      logic [31:0] d;
      int lat;
      acc(1'b0, a, '0, 1'b0, ci, lk, ul, d, lat);
      chk(d == gold[a >> 2], r, d, gold[a >> 2]);
      if (exp_lat >= 0) chk(lat == exp_lat, {r, " latency"}, 32'(lat), 32'(exp_lat));
   endtask

   task automatic wr_chk(input int a, input logic [31:0] v, input bit wt, input bit ci,
                         input int exp_lat, input string r);
      logic [31:0] d;
      int lat;
      acc(1'b1, a, v, wt, ci, 1'b0, 1'b0, d, lat);
      if (exp_lat >= 0) chk(lat == exp_lat, {r, " latency"}, 32'(lat), 32'(exp_lat));
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      summary();
   end

   initial begin
      int wb0, sb0;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      req_wt = 1'b0; req_ci = 1'b0; req_lock = 1'b0; req_unlock = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!rsp_valid && !mem_req, "R1 idle outputs", {30'd0, rsp_valid, mem_req}, 32'd0);

      // R1 R3 R4: first access misses, clean fill, critical word first
      fill_n = 0;
      rd_chk(adr(1, 0, 2), 6, 0, 0, 0, "R1 R3 cold miss");
      chk(rd_beats == 4, "R3 fill beats", 32'(rd_beats), 32'd4);
      chk(fill_log[0] == 2 && fill_log[1] == 3 && fill_log[2] == 0 && fill_log[3] == 1,
          "R4 wrap order", 32'(fill_log[0] * 4096 + fill_log[1] * 256 + fill_log[2] * 16 + fill_log[3]),
          32'h2301);
      rd_chk(adr(1, 0, 0), 0, 0, 0, 0, "R2 read hit");

      // R6: copy-back store stays in the cache
      wr_chk(adr(1, 0, 1), 32'hDEAD_0001, 0, 0, 0, "R2 R6 copy-back hit");
      chk(bmem[adr(1, 0, 1) >> 2] == 32'hC0DE_0000 + 32'(adr(1, 0, 1) >> 2), "R6 memory untouched",
          bmem[adr(1, 0, 1) >> 2], 32'hC0DE_0000 + 32'(adr(1, 0, 1) >> 2));
      chk(wr_beats == 0, "R6 no write beats", 32'(wr_beats), 32'd0);
      rd_chk(adr(1, 0, 1), 0, 0, 0, 0, "R6 readback dirty");

      // R5: LRU ordering in set 0
      rd_chk(adr(2, 0, 0), 6, 0, 0, 0, "R5 fill invalid way");
      rd_chk(adr(1, 0, 0), 0, 0, 0, 0, "R5 touch tag1");
      rd_chk(adr(3, 0, 0), 6, 0, 0, 0, "R5 evict older tag2");
      rd_chk(adr(1, 0, 3), 0, 0, 0, 0, "R5 recent line kept");
      rd_chk(adr(2, 0, 1), 6, 0, 0, 0, "R5 evicted line misses");
      chk(wr_beats == 0, "R5 clean evictions", 32'(wr_beats), 32'd0);

      // R6: dirty eviction writes back before the fill
      wb0 = wr_beats;
      rd_chk(adr(4, 0, 0), 10, 0, 0, 0, "R6 dirty eviction");
      chk(wr_beats - wb0 == 4, "R6 write-back beats", 32'(wr_beats - wb0), 32'd4);
      chk(bmem[adr(1, 0, 1) >> 2] == 32'hDEAD_0001, "R6 written back", bmem[adr(1, 0, 1) >> 2],
          32'hDEAD_0001);
      rd_chk(adr(1, 0, 1), 6, 0, 0, 0, "R6 refetch written value");

      // R7: write-through
      sb0 = single_beats;
      wr_chk(adr(1, 1, 0), 32'hBEEF_0100, 1, 0, 1, "R7 wt miss");
      chk(bmem[adr(1, 1, 0) >> 2] == 32'hBEEF_0100, "R7 wt miss memory", bmem[adr(1, 1, 0) >> 2],
          32'hBEEF_0100);
      chk(single_beats - sb0 == 1, "R7 one beat", 32'(single_beats - sb0), 32'd1);
      rd_chk(adr(1, 1, 0), 6, 0, 0, 0, "R7 no allocate");
      wr_chk(adr(1, 1, 3), 32'hBEEF_0103, 1, 0, 1, "R7 wt hit");
      chk(bmem[adr(1, 1, 3) >> 2] == 32'hBEEF_0103, "R7 wt hit memory", bmem[adr(1, 1, 3) >> 2],
          32'hBEEF_0103);
      rd_chk(adr(1, 1, 3), 0, 0, 0, 0, "R7 line updated");

      // R8: cache-inhibited
      rd_chk(adr(1, 2, 1), 1, 1, 0, 0, "R8 ci read");
      rd_chk(adr(1, 2, 1), 6, 0, 0, 0, "R8 ci no allocate");
      wr_chk(adr(5, 2, 2), 32'hC1C1_0522, 0, 1, 1, "R8 ci write");
      chk(bmem[adr(5, 2, 2) >> 2] == 32'hC1C1_0522, "R8 ci write memory", bmem[adr(5, 2, 2) >> 2],
          32'hC1C1_0522);
      rd_chk(adr(5, 2, 2), 1, 1, 0, 0, "R8 ci readback");

      // R9 R10: locking in set 3
      rd_chk(adr(1, 3, 0), 6, 0, 1, 0, "R9 lock tag1");
      rd_chk(adr(2, 3, 0), 6, 0, 1, 0, "R9 lock tag2");
      rd_chk(adr(3, 3, 0), 1, 0, 0, 0, "R10 both locked uncached");
      rd_chk(adr(3, 3, 1), 1, 0, 0, 0, "R10 still not allocated");
      rd_chk(adr(1, 3, 0), 0, 0, 0, 0, "R9 locked tag1 kept");
      rd_chk(adr(2, 3, 0), 0, 0, 0, 0, "R9 locked tag2 kept");
      rd_chk(adr(1, 3, 2), 0, 0, 0, 1, "R9 unlock tag1");
      rd_chk(adr(3, 3, 0), 6, 0, 0, 0, "R9 unlocked way replaced");
      rd_chk(adr(2, 3, 1), 0, 0, 0, 0, "R9 locked way skipped by LRU");
      rd_chk(adr(1, 3, 0), 6, 0, 0, 0, "R9 unlocked line evicted");

      // R11: sweep over sets and words with alternating policy
      for (int t = 8; t < 12; t++)
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WORDS; w++) begin
               wr_chk(adr(t, s, w), 32'h1000_0000 + 32'(t * 256 + s * 16 + w), w[0], 0, -1, "R11 store");
               rd_chk(adr(t, s, w), -1, 0, 0, 0, "R11 readback");
            end
      for (int t = 8; t < 12; t++)
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WORDS; w++)
               rd_chk(adr(t, s, w), -1, 0, 0, 0, "R11 final image");
      rd_chk(adr(1, 0, 1), -1, 0, 0, 0, "R11 early store");
      rd_chk(adr(1, 1, 3), -1, 0, 0, 0, "R11 wt store");

      summary();
   end
endmodule